// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block turns one input clock into two single-cycle clock enables: one for the CPU core and one for the peripheral group of timers, serial ports and interrupt logic. Downstream flops use these enables instead of gated clocks, so no clock edge is ever shortened. Software selects the run rate and the low-power mode through a small write port. A read port returns the active divide field and the two mode request bits.

Four modes are supported. Normal mode runs both enables at the selected rate. The rate is either the full clock or an economy ratio of 1/4, 1/64 or 1/1024. Idle mode stops the CPU enable while the peripheral enable keeps ticking, and any enabled interrupt ends it. Power-down stops both enables. An enabled external interrupt or a reset ends power-down, and after an external wake the enables stay off for a fixed settling count before they resume.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low, and for two clocks after it rises, both enables are low. After that the block is in normal mode at divide-by-1: `reg_rdata` reads 0 and both enables are high on every clock.
- R2: A write in normal mode loads `reg_wdata[1:0]` as the divide select, with 00 = /1, 01 = /4, 10 = /64 and 11 = /1024. `reg_rdata[1:0]` returns the select. In normal mode at ratio N, both enables pulse together for one clock every N clocks.
- R3: A new divide select takes effect only at the terminal count of the ratio already running. The pulse spacing in progress always completes at the old ratio.
- R4: A write in normal mode with `reg_wdata[2]`=1 and `reg_wdata[3]`=0 enters idle. `reg_rdata[2]` then reads 1, `cpu_ce` stays low, and `per_ce` keeps pulsing at the active ratio.
- R5: In idle, an interrupt line whose `irq_en` bit is 0 has no effect. The block stays in idle with `cpu_ce` low.
- R6: In idle, any line with both `irq_req` and `irq_en` high returns the block to normal mode on the next clock. `reg_rdata[2]` clears, and `cpu_ce` restarts on the next `per_ce` pulse, together with it.
- R7: A write in normal mode with `reg_wdata[3]`=1 enters power-down, even if bit 2 is also set. `reg_rdata[3]` reads 1 and `reg_rdata[2]` reads 0, and both enables stay low.
- R8: In power-down, only enabled lines among the lowest `NEXT` interrupt lines wake the block. Enabled lines at higher indices are ignored.
- R9: After an external wake, both enables stay low for exactly `WAKE_CYCLES` clocks, counted from the clock that samples the interrupt. Then the block returns to normal mode, the divider restarts from zero and `reg_rdata[3]` clears.
- R10: Writes are ignored in any mode other than normal. The divide select seen on `reg_rdata[1:0]` does not change there.
- R11: Asserting `rst_n` during power-down returns the block to normal mode at divide-by-1, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| reg_we | input | 1 | Write strobe for the mode/divide register |
| reg_wdata | input | 4 | [1:0] divide select, [2] idle request, [3] power-down request |
| reg_rdata | output | 4 | [1:0] divide select, [2] in idle, [3] in power-down or wake settling |
| irq_req | input | NIRQ | Interrupt request lines; the lowest NEXT are external |
| irq_en | input | NIRQ | Per-line interrupt enable |
| cpu_ce | output | 1 | CPU core clock enable |
| per_ce | output | 1 | Peripheral group clock enable |

## Verification
Two functions can meet in one clock. The first case is a divide-select write that arrives while the divider is at its terminal count. At /1 every clock is terminal, so a write there must switch ratio at once with no extra pulse. At /64 a write lands mid-count, and the bench expects a last 64-clock gap followed by 4-clock gaps, checked gap by gap in a scoreboard. The second case is a single write that carries both the idle and the power-down request; it must land in power-down, judged from the read-back bits and from both enables staying silent.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;

  localparam int unsigned DSEL_W = 2;
  localparam int unsigned REG_W  = 4;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  // Assert asynchronously, release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/pmc_divider.sv
module pmc_divider #(
  parameter int unsigned DIV_R1 = 4,
  parameter int unsigned DIV_R2 = 64,
  parameter int unsigned DIV_R3 = 1024
) (
  input  logic                      clk,
  input  logic                      srst_n,
  input  logic                      run,
  input  logic [pmc_pkg::DSEL_W-1:0] dsel,
  output logic                      tick,
  output logic [pmc_pkg::DSEL_W-1:0] dact
);

  localparam int unsigned CNT_W = $clog2(DIV_R3);
  localparam int unsigned RATIO [4] = '{1, DIV_R1, DIV_R2, DIV_R3};

  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic [pmc_pkg::DSEL_W-1:0] dact_q, dact_d;
  logic [CNT_W-1:0]           lim;
  logic                       tc;

  assign lim = CNT_W'(RATIO[dact_q] - 1);
  assign tc  = (cnt_q == lim);

  // The active ratio is reloaded only at the terminal count or while stopped.
  always_comb begin
    cnt_d  = cnt_q;
    dact_d = dact_q;
    if (!run || tc) begin
      cnt_d  = '0;
      dact_d = dsel;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      dact_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      dact_q <= dact_d;
    end
  end

  assign tick = run & tc;
  assign dact = dact_q;

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm #(
  parameter int unsigned NIRQ        = 12,
  parameter int unsigned NEXT        = 6,
  parameter int unsigned WAKE_CYCLES = 1024
) (
  input  logic                       clk,
  input  logic                       srst_n,
  input  logic                       wr_en,
  input  logic [pmc_pkg::REG_W-1:0]  wdata,
  input  logic [NIRQ-1:0]            irq_req,
  input  logic [NIRQ-1:0]            irq_en,
  output pmc_pkg::pm_state_e         state,
  output logic [pmc_pkg::DSEL_W-1:0] dsel
);
  import pmc_pkg::*;

  localparam int unsigned     WK_W     = $clog2(WAKE_CYCLES + 1);
  localparam logic [WK_W-1:0] WK_LAST  = WK_W'(WAKE_CYCLES - 1);
  localparam logic [NIRQ-1:0] EXT_MASK = ~({NIRQ{1'b1}} << NEXT);

  pm_state_e          st_q, st_d;
  logic [DSEL_W-1:0]  ds_q, ds_d;
  logic [WK_W-1:0]    wk_q, wk_d;
  logic               any_irq, ext_irq;

  assign any_irq = |(irq_req & irq_en);
  assign ext_irq = |(irq_req & irq_en & EXT_MASK);

  always_comb begin
    st_d = st_q;
    ds_d = ds_q;
    wk_d = wk_q;
    unique case (st_q)
      PM_RUN: begin
        if (wr_en) begin
          ds_d = wdata[1:0];
          if (wdata[3])      st_d = PM_DOWN;
          else if (wdata[2]) st_d = PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (any_irq) st_d = PM_RUN;
      end
      PM_DOWN: begin
        wk_d = '0;
        if (ext_irq) st_d = PM_WAKE;
      end
      PM_WAKE: begin
        if (wk_q == WK_LAST) st_d = PM_RUN;
        else                 wk_d = wk_q + 1'b1;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= PM_RUN;
      ds_q <= '0;
      wk_q <= '0;
    end else begin
      st_q <= st_d;
      ds_q <= ds_d;
      wk_q <= wk_d;
    end
  end

  assign state = st_q;
  assign dsel  = ds_q;

endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
  parameter int unsigned NIRQ        = 12,
  parameter int unsigned NEXT        = 6,
  parameter int unsigned DIV_R1      = 4,
  parameter int unsigned DIV_R2      = 64,
  parameter int unsigned DIV_R3      = 1024,
  parameter int unsigned WAKE_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [3:0]      reg_wdata,
  output logic [3:0]      reg_rdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            cpu_ce,
  output logic            per_ce
);
  import pmc_pkg::*;

  logic              srst_n;
  pm_state_e         state;
  logic [DSEL_W-1:0] dsel, dact;
  logic              run, tick;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pmc_mode_fsm #(
    .NIRQ        (NIRQ),
    .NEXT        (NEXT),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (reg_we),
    .wdata   (reg_wdata),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .state   (state),
    .dsel    (dsel)
  );

  // The divider runs in normal and idle; it is held at zero otherwise.
  assign run = srst_n & ((state == PM_RUN) | (state == PM_IDLE));

  pmc_divider #(
    .DIV_R1 (DIV_R1),
    .DIV_R2 (DIV_R2),
    .DIV_R3 (DIV_R3)
  ) u_div (
    .clk    (clk),
    .srst_n (srst_n),
    .run    (run),
    .dsel   (dsel),
    .tick   (tick),
    .dact   (dact)
  );

  assign per_ce    = tick;
  assign cpu_ce    = tick & (state == PM_RUN);
  assign reg_rdata = {(state == PM_DOWN) | (state == PM_WAKE), state == PM_IDLE, dsel};

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned NIRQ = 12,
  parameter int unsigned NEXT = 6
) (
  input logic               clk,
  input logic               srst_n,
  input pmc_pkg::pm_state_e state,
  input logic [1:0]         dact,
  input logic               tick,
  input logic               cpu_ce,
  input logic               per_ce,
  input logic [NIRQ-1:0]    irq_req,
  input logic [NIRQ-1:0]    irq_en,
  input logic [3:0]         reg_rdata
);
  import pmc_pkg::*;

  localparam logic [NIRQ-1:0] EXT_MASK = ~({NIRQ{1'b1}} << NEXT);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (dact != 2'b00 && tick) |=> !tick);

  p_cpu_within_per_r4: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_ce |-> per_ce);

  p_idle_cpu_off_r4: assert property (@(posedge clk) disable iff (!srst_n)
    reg_rdata[2] |-> !cpu_ce);

  p_masked_idle_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (state == PM_IDLE && (irq_req & irq_en) == '0) |=> state == PM_IDLE);

  p_idle_wake_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (state == PM_IDLE && (irq_req & irq_en) != '0) |=> state == PM_RUN);

  p_down_quiet_r7: assert property (@(posedge clk) disable iff (!srst_n)
    reg_rdata[3] |-> (!per_ce && !cpu_ce));

  p_internal_ignored_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (state == PM_DOWN && (irq_req & irq_en & EXT_MASK) == '0) |=> state == PM_DOWN);

  p_div_frozen_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (state != PM_RUN) |=> $stable(reg_rdata[1:0]));

endmodule

bind pmc_top pmc_checker #(.NIRQ(NIRQ), .NEXT(NEXT)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .state     (state),
  .dact      (dact),
  .tick      (tick),
  .cpu_ce    (cpu_ce),
  .per_ce    (per_ce),
  .irq_req   (irq_req),
  .irq_en    (irq_en),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_pmc_top.sv
module tb_pmc_top;

  localparam int NIRQ  = 12;
  localparam int WAKEN = 1024;

  logic            clk;
  logic            rst_n;
  logic            reg_we;
  logic [3:0]      reg_wdata;
  logic [3:0]      reg_rdata;
  logic [NIRQ-1:0] irq_req;
  logic [NIRQ-1:0] irq_en;
  logic            cpu_ce;
  logic            per_ce;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_cyc = 0;
  bit have_last = 0;
  int    q_gap[$];
  string q_req[$];

  pmc_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .cpu_ce    (cpu_ce),
    .per_ce    (per_ce)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: measures the spacing of cpu_ce pulses and compares with the queue.
  always @(negedge clk) begin
    cyc++;
    if (cpu_ce) begin
      if (have_last && q_gap.size() > 0) begin
        int    g;
        string r;
        g = q_gap.pop_front();
        r = q_req.pop_front();
        check(cyc - last_cyc == g, r, cyc - last_cyc, g);
        if (cpu_ce != per_ce) check(1'b0, r, int'(per_ce), 1);
      end
      last_cyc  = cyc;
      have_last = 1'b1;
    end
  end

  task automatic push_gap(input int g, input string r);
    q_gap.push_back(g);
    q_req.push_back(r);
  endtask

  task automatic drain();
    while (q_gap.size() != 0) @(negedge clk);
  endtask

  task automatic expect_gaps(input int n, input int g, input string r);
    @(negedge clk);
    while (!cpu_ce) @(negedge clk);
    #1;
    for (int i = 0; i < n; i++) push_gap(g, r);
    drain();
  endtask

  task automatic reg_write(input logic [3:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int cnt;
    bit seen;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_wdata = '0;
    irq_req   = '0;
    irq_en    = '0;

    // R1: quiet in reset, then /1 normal mode
    repeat (3) @(negedge clk);
    check(!cpu_ce && !per_ce, "R1 reset enables", int'(cpu_ce | per_ce), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_ce && !per_ce, "R1 sync release", int'(cpu_ce | per_ce), 0);
    repeat (2) @(negedge clk);
    check(cpu_ce && per_ce, "R1 enables after reset", int'(cpu_ce & per_ce), 1);
    check(reg_rdata == 4'h0, "R1 rdata after reset", int'(reg_rdata), 0);
    expect_gaps(4, 1, "R1 divide-by-1");

    // R2: each economy ratio
    reg_write(4'b0001);
    check(reg_rdata == 4'b0001, "R2 select readback", int'(reg_rdata), 1);
    expect_gaps(4, 4, "R2 divide-by-4");
    reg_write(4'b0010);
    expect_gaps(3, 64, "R2 divide-by-64");
    reg_write(4'b0011);
    expect_gaps(2, 1024, "R2 divide-by-1024");

    // R3: ratio change mid-count completes the old spacing first
    reg_write(4'b0010);
    expect_gaps(1, 64, "R3 back to 64");
    repeat (10) @(negedge clk);
    #1;
    push_gap(64, "R3 old ratio completes");
    push_gap(4, "R3 new ratio");
    push_gap(4, "R3 new ratio");
    reg_write(4'b0001);
    drain();

    // R4: idle keeps per_ce at /4, stops cpu_ce
    reg_write(4'b0101);
    check(reg_rdata == 4'b0101, "R4 idle readback", int'(reg_rdata), 5);
    cnt = 0; seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (per_ce) cnt++;
      if (cpu_ce) seen = 1;
    end
    check(!seen, "R4 cpu_ce in idle", int'(seen), 0);
    check(cnt == 10, "R4 per_ce pulses in 40 clocks", cnt, 10);

    // R5: disabled interrupt ignored
    irq_req[3] = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cpu_ce) seen = 1;
    end
    irq_req = '0;
    check(!seen, "R5 cpu_ce with masked irq", int'(seen), 0);
    check(reg_rdata[2], "R5 still idle", int'(reg_rdata[2]), 1);

    // R10: write ignored while idle
    reg_write(4'b0011);
    check(reg_rdata == 4'b0101, "R10 write ignored in idle", int'(reg_rdata), 5);

    // R6: enabled internal interrupt wakes from idle
    @(negedge clk);
    irq_en[9]  = 1'b1;
    irq_req[9] = 1'b1;
    @(negedge clk);
    irq_req = '0;
    check(reg_rdata == 4'b0001, "R6 idle bit cleared", int'(reg_rdata), 1);
    cnt = 1;
    while (!cpu_ce && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt <= 4, "R6 cpu_ce within one tick", cnt, 4);
    check(per_ce, "R6 cpu_ce aligned to per_ce", int'(per_ce), 1);
    expect_gaps(2, 4, "R6 normal /4 after idle");

    // R7: power-down wins over idle in the same write
    reg_write(4'b1100);
    check(reg_rdata == 4'b1000, "R7 power-down readback", int'(reg_rdata), 8);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cpu_ce || per_ce) seen = 1;
    end
    check(!seen, "R7 enables in power-down", int'(seen), 0);

    // R8: internal interrupt does not wake power-down
    irq_en = '1;
    irq_req[8] = 1'b1;
    repeat (5) @(negedge clk);
    irq_req = '0;
    seen = 0;
    for (int i = 0; i < WAKEN + 100; i++) begin
      @(negedge clk);
      if (cpu_ce || per_ce) seen = 1;
    end
    check(!seen, "R8 internal irq ignored", int'(seen), 0);
    check(reg_rdata[3], "R8 still powered down", int'(reg_rdata[3]), 1);

    // R9: external wake, exact settling count
    irq_req[2] = 1'b1;
    @(negedge clk);
    irq_req = '0;
    cnt = 0;
    while (!cpu_ce && cnt < WAKEN + 50) begin
      if (cnt == WAKEN / 2)
        check(reg_rdata[3], "R9 settling readback", int'(reg_rdata[3]), 1);
      cnt++;
      @(negedge clk);
    end
    check(cnt == WAKEN, "R9 settling clocks", cnt, WAKEN);
    check(reg_rdata == 4'b0000, "R9 power-down bit cleared", int'(reg_rdata), 0);
    check(per_ce, "R9 per_ce resumes", int'(per_ce), 1);

    // R11: reset ends power-down
    reg_write(4'b1001);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(reg_rdata == 4'b0000, "R11 rdata after reset", int'(reg_rdata), 0);
    check(cpu_ce && per_ce, "R11 enables after reset", int'(cpu_ce & per_ce), 1);
    expect_gaps(3, 1, "R11 divide-by-1");

    finish_run();
  end

endmodule